// File: doc/BRIEF.md
# Correction Flag Monitor Output

This block sits beside a two-stage (inner and outer) Reed-Solomon style corrector. It captures a set of per-frame status flags and presents them on a shared group of four output pins. The corrector supplies three inputs for each frame:

- how many symbol errors the inner stage found;
- how many inner-stage pointers fall inside the outer codeword;
- whether the outer stage ran.

These are captured on a single-cycle correction-done strobe. The block derives four monitor flags from them, plus a combined outer-stage flag.

Captured flags stay put until the frame clock falls. After the fall, a release timer counts ticks of a slow enable (nominally 2.1168 MHz), so the flags drop no sooner than one tick period after the frame clock deasserts.

A select input chooses what the pins carry: when high, the four normal serial audio bits pass through unchanged; when low, the four monitor flags drive the pins. Outer-stage pointers mark unreliable 16-bit words, which downstream logic hides by previous-value hold or mean-value interpolation. The combined flag lets that logic or a tester see when the outer stage worked with inner pointers present.

All data inputs are plain sampled signals. The strobe is a one-cycle valid with no ready, so the block never applies back-pressure. Every strobe is accepted in the cycle it is high.

Top module: `corr_flag_monitor`

## Requirements
- R1: After reset all four monitor flags and the combined flag are low, and with select low the pins read 4'b0000.
- R2: On a strobe, pin bit 0 (inner-stage error flag) is captured high when the inner error count is nonzero.
- R3: On a strobe, pin bit 1 (inner-stage failure flag) is captured high when the inner error count exceeds C1_FIX_MAX (default 2, double-error correction).
- R4: On a strobe, pin bit 2 is captured high when at least one inner pointer lies in the outer codeword.
- R5: On a strobe, pin bit 3 is captured high when the outer stage ran on that frame.
- R6: The combined flag output equals the AND of flag bits 2 and 3 as currently held.
- R7: Between a strobe and its release, the held flags do not change; count and run inputs that change without a strobe have no effect on the pins.
- R8: After the frame clock is seen falling, the flags clear on the clock edge of the RELEASE_TICKS-th tick that arrives in a later cycle, and not before. A tick in the fall cycle itself is not counted.
- R9: A strobe while a release is pending cancels it. The new flags are then held until the next frame-clock fall, and a strobe in the same cycle as a fall or release wins over both.
- R10: With select high, the pins equal the four audio input bits in every cycle; with select low, they show the held flags in bit order 3:0 = outer-ran, outer-pointer, inner-fail, inner-error.
- R11: A fresh frame-clock fall while a release is counting restarts the tick count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_tick_i | input | 1 | One-cycle enable at the release timing rate |
| frame_clk_i | input | 1 | Frame clock level, sampled synchronously |
| corr_done_i | input | 1 | One-cycle strobe: frame correction finished, status valid |
| c1_err_cnt_i | input | ERR_W | Symbol errors found by the inner stage |
| c2_ptr_cnt_i | input | PTR_W | Inner pointers present in the outer codeword |
| c2_run_i | input | 1 | Outer stage executed on this frame |
| data_sel_i | input | 1 | 1: pins carry audio bits, 0: pins carry monitor flags |
| audio_bits_i | input | 4 | Normal serial data bits |
| pin_o | output | 4 | Shared output pins |
| c2_flag_o | output | 1 | Combined outer-stage flag |

## Verification
The bench builds the block with its defaults: ERR_W=3, PTR_W=5, C1_FIX_MAX=2 and RELEASE_TICKS=2.

A 3-bit error count spans counts on both sides of the failure threshold, up to the maximum value 7. This exercises both inner flags independently.

A two-tick release leaves a window in which a second fall or a new strobe can land partway through the count. This brings the restart and override paths within reach. Random tick spacing places the first tick both in the fall cycle and in later cycles.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int NUM_MON = 4;

  typedef struct packed {
    logic c2_ran;
    logic c2_ptr;
    logic c1_fail;
    logic c1_err;
  } cfm_flags_t;
endpackage

// File: rtl/cfm_flag_encode.sv
module cfm_flag_encode
  import cfm_pkg::*;
#(
  parameter int ERR_W      = 3,
  parameter int PTR_W      = 5,
  parameter int C1_FIX_MAX = 2
) (
  input  logic [ERR_W-1:0] c1_err_cnt_i,
  input  logic [PTR_W-1:0] c2_ptr_cnt_i,
  input  logic             c2_run_i,
  output cfm_flags_t       flags_o
);
  localparam logic [ERR_W-1:0] FixLim = ERR_W'(C1_FIX_MAX);

  always_comb begin
    flags_o.c1_err  = (c1_err_cnt_i != '0);
    flags_o.c1_fail = (c1_err_cnt_i > FixLim);
    flags_o.c2_ptr  = (c2_ptr_cnt_i != '0);
    flags_o.c2_ran  = c2_run_i;
  end
endmodule

// File: rtl/cfm_release_timer.sv
module cfm_release_timer #(
  parameter int RELEASE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk_i,
  input  logic tick_i,
  input  logic cancel_i,
  output logic release_o
);
  localparam int CNT_W = (RELEASE_TICKS < 2) ? 1 : $clog2(RELEASE_TICKS);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(RELEASE_TICKS - 1);

  logic             frame_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall      = frame_q & ~frame_clk_i;
  assign release_o = armed_q & tick_i & (cnt_q == LastCnt) & ~cancel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_clk_i;
      if (cancel_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (release_o) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (int'(cnt_q) < RELEASE_TICKS)); // R8
  AST_CANCEL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !armed_q); // R9
  AST_FALL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !cancel_i && !release_o) |=> (armed_q && cnt_q == '0)); // R11
endmodule

// File: rtl/cfm_flag_hold.sv
module cfm_flag_hold
  import cfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  cfm_flags_t flags_i,
  input  logic       release_i,
  output cfm_flags_t flags_o
);
  cfm_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (load_i)    flags_q <= flags_i;
    else if (release_i) flags_q <= '0;
  end

  assign flags_o = flags_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !release_i) |=> $stable(flags_q)); // R7
  AST_CLEAR_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !load_i) |=> (flags_q == '0)); // R8
endmodule

// File: rtl/corr_flag_monitor.sv
module corr_flag_monitor
  import cfm_pkg::*;
#(
  parameter int ERR_W         = 3,
  parameter int PTR_W         = 5,
  parameter int C1_FIX_MAX    = 2,
  parameter int RELEASE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_tick_i,
  input  logic             frame_clk_i,
  input  logic             corr_done_i,
  input  logic [ERR_W-1:0] c1_err_cnt_i,
  input  logic [PTR_W-1:0] c2_ptr_cnt_i,
  input  logic             c2_run_i,
  input  logic             data_sel_i,
  input  logic [3:0]       audio_bits_i,
  output logic [3:0]       pin_o,
  output logic             c2_flag_o
);
  cfm_flags_t new_flags;
  cfm_flags_t held_flags;
  logic       release_pulse;

  cfm_flag_encode #(
    .ERR_W(ERR_W), .PTR_W(PTR_W), .C1_FIX_MAX(C1_FIX_MAX)
  ) u_encode (
    .c1_err_cnt_i(c1_err_cnt_i),
    .c2_ptr_cnt_i(c2_ptr_cnt_i),
    .c2_run_i    (c2_run_i),
    .flags_o     (new_flags)
  );

  cfm_release_timer #(.RELEASE_TICKS(RELEASE_TICKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clk_i(frame_clk_i),
    .tick_i     (mon_tick_i),
    .cancel_i   (corr_done_i),
    .release_o  (release_pulse)
  );

  cfm_flag_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (corr_done_i),
    .flags_i  (new_flags),
    .release_i(release_pulse),
    .flags_o  (held_flags)
  );

  assign c2_flag_o = held_flags.c2_ptr & held_flags.c2_ran;
  assign pin_o     = data_sel_i ? audio_bits_i : held_flags;

  AST_C2FL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c2_flag_o) |-> $past(corr_done_i && c2_run_i && (c2_ptr_cnt_i != '0))); // R6
  AST_AUDIO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    data_sel_i |-> (pin_o == audio_bits_i)); // R10
endmodule

// File: tb/corr_flag_monitor_bench.sv
module corr_flag_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 3;
  localparam int PTR_W = 5;
  localparam int FIXMAX = 2;
  localparam int RT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, frame = 1'b0, done = 1'b0, run = 1'b0, sel = 1'b0;
  logic [ERR_W-1:0] err = '0;
  logic [PTR_W-1:0] ptr = '0;
  logic [3:0] audio = '0;
  logic [3:0] pin;
  logic c2fl;

  int checks = 0, errors = 0;
  bit finished = 0;
  string req = "R1";

  logic [3:0] m_flags = '0;
  logic m_fq = 1'b0, m_armed = 1'b0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_flag_monitor #(.ERR_W(ERR_W), .PTR_W(PTR_W), .C1_FIX_MAX(FIXMAX),
    .RELEASE_TICKS(RT)) u_corr_flag_monitor (
    .clk(clk), .rst_n(rst_n), .mon_tick_i(tick), .frame_clk_i(frame),
    .corr_done_i(done), .c1_err_cnt_i(err), .c2_ptr_cnt_i(ptr),
    .c2_run_i(run), .data_sel_i(sel), .audio_bits_i(audio),
    .pin_o(pin), .c2_flag_o(c2fl));

  function automatic logic [3:0] enc(input logic [ERR_W-1:0] e,
                                     input logic [PTR_W-1:0] p, input logic r);
    return {r, p != 0, int'(e) > FIXMAX, e != 0};
  endfunction

  function automatic logic [3:0] exp_pin();
    return sel ? audio : m_flags;
  endfunction

  task automatic model_step();
    logic fall;
    logic rel;
    fall = m_fq & ~frame;
    rel  = m_armed & tick & (m_cnt == RT - 1);
    if (done) begin
      m_flags = enc(err, ptr, run); m_armed = 0; m_cnt = 0;
    end else if (rel) begin
      m_flags = '0; m_armed = 0; m_cnt = 0;
    end else if (fall) begin
      m_armed = 1; m_cnt = 0;
    end else if (m_armed && tick) begin
      m_cnt++;
    end
    m_fq = frame;
  endtask

  task automatic check(input logic [3:0] ep, input logic ef);
    checks++;
    if (pin !== ep) begin
      errors++;
      $display("FAIL %s pins actual %b expected %b", req, pin, ep);
    end
    checks++;
    if (c2fl !== ef) begin
      errors++;
      $display("FAIL %s c2 flag actual %b expected %b", req, c2fl, ef);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(exp_pin(), m_flags[3] & m_flags[2]);
    done = 0; tick = 0;
  endtask

  task automatic strobe(input logic [ERR_W-1:0] e, input logic [PTR_W-1:0] p,
                        input logic r);
    err = e; ptr = p; run = r; done = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; check(4'b0000, 1'b0); step();

    frame = 1;
    req = "R2"; strobe(3'd1, 5'd0, 0);
    req = "R3"; strobe(3'd2, 5'd0, 0);
    strobe(3'd3, 5'd0, 0);
    strobe(3'd7, 5'd0, 0);
    req = "R4"; strobe(3'd0, 5'd1, 0);
    req = "R5"; strobe(3'd0, 5'd0, 1);
    req = "R6"; strobe(3'd0, 5'd31, 1);
    check(4'b1100, 1'b1);
    req = "R7"; err = 3'd0; ptr = 5'd0; run = 0; step(); step();
    check(4'b1100, 1'b1);

    req = "R8"; strobe(3'd5, 5'd2, 1);
    frame = 0; tick = 1; step();
    step();
    tick = 1; step();
    check(4'b1111, 1'b1);
    tick = 1; step();
    check(4'b0000, 1'b0);

    req = "R9"; frame = 1; strobe(3'd1, 5'd1, 1);
    frame = 0; step();
    tick = 1; step();
    strobe(3'd3, 5'd0, 0);
    tick = 1; step(); tick = 1; step();
    check(4'b0011, 1'b0);
    frame = 1; step(); frame = 0; err = 3'd0; done = 1; step();
    tick = 1; step(); tick = 1; step();
    check(4'b0000, 1'b0);

    req = "R11"; frame = 1; strobe(3'd4, 5'd0, 1);
    frame = 0; step(); tick = 1; step();
    frame = 1; step(); frame = 0; step();
    tick = 1; step();
    check(4'b1011, 1'b0);
    tick = 1; step();
    check(4'b0000, 1'b0);

    req = "R10"; sel = 1;
    for (int i = 0; i < 16; i++) begin audio = 4'(i); step(); end
    sel = 0; step();

    req = "R8 R9 R10 R11 random";
    for (int i = 0; i < 4000; i++) begin
      tick  = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) frame = ~frame;
      done  = ($urandom % 10) == 0;
      err   = ERR_W'($urandom);
      ptr   = (($urandom % 2) == 0) ? '0 : PTR_W'($urandom);
      run   = $urandom % 2;
      sel   = ($urandom % 4) == 0;
      audio = 4'($urandom);
      step();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule